// File: doc/BRIEF.md
# Locked Trace Buffer Readout Window

This block holds a circular store of 64-bit trace lines and lets a 16-bit register bus read that store out through one word-wide window. While the module is armed, a capture strobe writes one line per cycle into the store at a circular write position, which restarts at line 0 each time the module is armed. The bus reads each line as four consecutive 16-bit words, most significant word first. An internal read position moves forward by one word on every qualified read. After the fourth word it moves to the next line, and after the last line it returns to line 0.

Reads are guarded by a lock. Arming sets the lock. Disarming leaves it set. Only an aligned, full-word write to the window made while the module is disarmed clears it, and that write never alters the stored lines. A read of the wrong kind returns zero and does not move the read position. The wrong kinds are a byte read, a read at an odd address, a read while armed or locked, and a read while the device is secured. A system reset keeps the stored lines, but their power-on contents are undefined.

The lock is a three-state machine. LOCKED is the reset state. From LOCKED the machine takes transition T_ARM to ARMED when the arm input is high. Otherwise it takes T_UNLOCK to OPEN on a qualifying unlock write. From OPEN it takes T_ARM to ARMED when the arm input is high. From ARMED it takes T_DISARM to LOCKED when the arm input falls. In every state other than OPEN, the read position tracks the oldest stored line.

Top module: `trbuf_window`

## Requirements
- R1: A line is returned as four reads. Word index 0 carries bits 63:48, index 1 bits 47:32, index 2 bits 31:16 and index 3 bits 15:0.
- R2: Each qualified read advances the word index. After index 3 the line index advances, and after line 63 it wraps to line 0.
- R3: A read made while `armed_i` is high returns zero and does not advance the read position. This holds even in the cycle that `armed_i` first rises.
- R4: After disarming, reads return zero until an unlock write is made. An unlock write has both byte enables set (`acc_be_i` = 2'b11) and `acc_addr0_i` = 0, and is made while `armed_i` is low. An unlock write made while armed does not unlock. An unlock write never changes stored lines.
- R5: A read with `acc_be_i` other than 2'b11, or with `acc_addr0_i` = 1, returns zero and does not advance the read position.
- R6: A read while `secured_i` is high returns zero and does not advance the read position.
- R7: While armed, each cycle with `cap_valid_i` high stores `cap_data_i` at the write position. The write position starts at line 0 after arming and wraps after line 63. A capture in the cycle `armed_i` falls is still stored.
- R8: After unlocking, reading starts at word 0 of the oldest line. That is line 0 if fewer than 64 lines were captured since arming, and otherwise the line after the newest one.
- R9: Reset clears `rdata_o`, `rvalid_o`, the write position and the full condition, and leaves the lock set. Stored lines survive reset.
- R10: Every read request is answered one cycle later, with `rvalid_o` high and `rdata_o` holding the word or zero. Write requests produce no response.
- R11: A write with a byte enable cleared or with `acc_addr0_i` = 1 does not unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| armed_i | input | 1 | Module armed level |
| secured_i | input | 1 | Device secured level; blocks reads |
| cap_valid_i | input | 1 | Capture strobe for one trace line |
| cap_data_i | input | 64 | Trace line to store |
| acc_valid_i | input | 1 | Bus access to the window this cycle |
| acc_write_i | input | 1 | 1 for write, 0 for read |
| acc_addr0_i | input | 1 | Address bit 0; 1 means misaligned |
| acc_be_i | input | 2 | Byte enables, both set for a word access |
| rdata_o | output | 16 | Read word, zero for an unqualified read |
| rvalid_o | output | 1 | Read response strobe, one cycle after a read |

## Verification
Two pairs of events can land in the same cycle. The first is a bus read and the rise of the arm input. The bench drives a read together with the first high cycle of `armed_i` while the lock is open, and requires a zero answer, not the next word. The second is a capture strobe and the fall of the arm input. The bench drives both at once and then requires that line to come back at its expected position once the store is unlocked. A scoreboard holds the word expected for every read, and after each response the bench reads on to confirm that no word was skipped.

// File: rtl/trbuf_pkg.sv
package trbuf_pkg;
    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_OPEN   = 2'd1,
        LK_ARMED  = 2'd2
    } lock_state_e;
endpackage

// File: rtl/trbuf_lock_fsm.sv
module trbuf_lock_fsm
    import trbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        armed_i,
    input  logic        unlock_i,
    output lock_state_e state_o,
    output logic        arm_start_o
);
    lock_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: begin
                if (armed_i)       state_d = LK_ARMED;   // T_ARM
                else if (unlock_i) state_d = LK_OPEN;    // T_UNLOCK
            end
            LK_OPEN: begin
                if (armed_i)       state_d = LK_ARMED;   // T_ARM
            end
            LK_ARMED: begin
                if (!armed_i)      state_d = LK_LOCKED;  // T_DISARM
            end
            default:               state_d = LK_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        state_o     = state_q;
        arm_start_o = armed_i && (state_q != LK_ARMED);
    end

    a_r4_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_LOCKED && !armed_i && !unlock_i) |=> (state_q == LK_LOCKED));
    a_r3_arm_locks: assert property (@(posedge clk) disable iff (!rst_n)
        armed_i |=> (state_q == LK_ARMED));
endmodule

// File: rtl/trbuf_store.sv
module trbuf_store #(
    parameter int DEPTH  = 64,
    parameter int LINE_W = 64,
    localparam int LINE_AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_start_i,
    input  logic               cap_en_i,
    input  logic [LINE_W-1:0]  cap_data_i,
    input  logic [LINE_AW-1:0] rd_line_i,
    output logic [LINE_W-1:0]  rd_data_o,
    output logic [LINE_AW-1:0] oldest_o
);
    localparam logic [LINE_AW-1:0] LAST = LINE_AW'(DEPTH - 1);

    logic [LINE_W-1:0]  mem [DEPTH];
    logic [LINE_AW-1:0] wr_q;
    logic               full_q;

    // storage: never reset, so contents survive a system reset
    always_ff @(posedge clk) begin
        if (cap_en_i) mem[wr_q] <= cap_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || arm_start_i) begin
            wr_q   <= '0;
            full_q <= 1'b0;
        end else if (cap_en_i) begin
            wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (wr_q == LAST) full_q <= 1'b1;
        end
    end

    assign rd_data_o = mem[rd_line_i];
    assign oldest_o  = full_q ? wr_q : '0;

    a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_i && !arm_start_i) |=> $stable(wr_q));
    a_r7_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
        arm_start_i |=> (oldest_o == '0));
endmodule

// File: rtl/trbuf_rdptr.sv
module trbuf_rdptr
    import trbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WORDS = 4,
    localparam int LINE_AW = $clog2(DEPTH),
    localparam int WORD_AW = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lock_state_e        state_i,
    input  logic               rd_fire_i,
    input  logic [LINE_AW-1:0] oldest_i,
    output logic [LINE_AW-1:0] line_o,
    output logic [WORD_AW-1:0] word_o
);
    localparam logic [LINE_AW-1:0] LINE_LAST = LINE_AW'(DEPTH - 1);
    localparam logic [WORD_AW-1:0] WORD_LAST = WORD_AW'(WORDS - 1);

    logic [LINE_AW-1:0] line_q;
    logic [WORD_AW-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            word_q <= '0;
        end else if (state_i != LK_OPEN) begin
            line_q <= oldest_i;
            word_q <= '0;
        end else if (rd_fire_i) begin
            if (word_q == WORD_LAST) begin
                word_q <= '0;
                line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
            end else begin
                word_q <= word_q + 1'b1;
            end
        end
    end

    assign line_o = line_q;
    assign word_o = word_q;

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == LK_OPEN && !rd_fire_i) |=> ($stable(line_q) && $stable(word_q)));
    a_r8_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != LK_OPEN) |=> (word_q == '0));
endmodule

// File: rtl/trbuf_window.sv
module trbuf_window
    import trbuf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LINE_W = 64,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed_i,
    input  logic              secured_i,
    input  logic              cap_valid_i,
    input  logic [LINE_W-1:0] cap_data_i,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic              acc_addr0_i,
    input  logic [1:0]        acc_be_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int WORDS   = LINE_W / WORD_W;
    localparam int LINE_AW = $clog2(DEPTH);
    localparam int WORD_AW = $clog2(WORDS);

    lock_state_e        state;
    logic               arm_start;
    logic [LINE_AW-1:0] rd_line, oldest;
    logic [WORD_AW-1:0] rd_word;
    logic [LINE_W-1:0]  line_data;
    logic [WORD_W-1:0]  word_sel;
    logic               rd_req, word_ok, rd_fire, unlock, cap_en;
    logic [WORD_W-1:0]  rdata_q;
    logic               rvalid_q;

    // access qualification
    always_comb begin
        rd_req  = acc_valid_i && !acc_write_i;
        word_ok = (acc_be_i == 2'b11) && !acc_addr0_i;
        rd_fire = rd_req && word_ok && (state == LK_OPEN) && !armed_i && !secured_i;
        unlock  = acc_valid_i && acc_write_i && word_ok && !armed_i;
        cap_en  = cap_valid_i && (state == LK_ARMED);
    end

    trbuf_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed_i     (armed_i),
        .unlock_i    (unlock),
        .state_o     (state),
        .arm_start_o (arm_start)
    );

    trbuf_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_start_i (arm_start),
        .cap_en_i    (cap_en),
        .cap_data_i  (cap_data_i),
        .rd_line_i   (rd_line),
        .rd_data_o   (line_data),
        .oldest_o    (oldest)
    );

    trbuf_rdptr #(.DEPTH(DEPTH), .WORDS(WORDS)) u_rdptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .rd_fire_i (rd_fire),
        .oldest_i  (oldest),
        .line_o    (rd_line),
        .word_o    (rd_word)
    );

    // word index 0 selects the most significant slice
    always_comb begin
        word_sel = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (rd_word == WORD_AW'(k))
                word_sel = line_data[(WORDS-1-k)*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rdata_q  <= rd_fire ? word_sel : '0;
            rvalid_q <= rd_req;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    a_r5_bad_kind_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !word_ok) |=> (rdata_o == '0));
    a_r3_armed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && armed_i) |=> (rdata_o == '0));
    a_r6_secure_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && secured_i) |=> (rdata_o == '0));
    a_r10_response: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid_o);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid_o);
endmodule

// File: tb/trbuf_window_tb_top.sv
`timescale 1ns/1ps
module trbuf_window_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        armed = 1'b0, secured = 1'b0, cap_valid = 1'b0;
    logic [63:0] cap_data = '0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_addr0 = 1'b0;
    logic [1:0]  acc_be = 2'b00;
    logic [15:0] rdata;
    logic        rvalid;

    always #2.5 clk = ~clk;

    trbuf_window dut_i (
        .clk(clk), .rst_n(rst_n), .armed_i(armed), .secured_i(secured),
        .cap_valid_i(cap_valid), .cap_data_i(cap_data),
        .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_addr0_i(acc_addr0), .acc_be_i(acc_be),
        .rdata_o(rdata), .rvalid_o(rvalid)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    logic [63:0] mem [64];
    int mwr = 0, mfull = 0, rl = 0, rw = 0;

    function automatic logic [63:0] mk(int i);
        return {16'hA000 | 16'(i), 16'hB000 | 16'(i), 16'hC000 | 16'(i), 16'hD000 | 16'(i)};
    endfunction

    function automatic logic [15:0] word_of(logic [63:0] d, int w);
        case (w)
            0: return d[63:48];
            1: return d[47:32];
            2: return d[31:16];
            default: return d[15:0];
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", rdata, 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic bus_read(logic [1:0] be, logic a0, bit ok, string tag);
        logic [15:0] e;
        e = ok ? word_of(mem[rl], rw) : 16'h0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (ok) begin
            rw++;
            if (rw == 4) begin rw = 0; rl = (rl + 1) % 64; end
        end
        acc_valid = 1'b1; acc_write = 1'b0; acc_be = be; acc_addr0 = a0;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic bus_write(logic [1:0] be, logic a0);
        acc_valid = 1'b1; acc_write = 1'b1; acc_be = be; acc_addr0 = a0;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic unlock_and_seek();
        bus_write(2'b11, 1'b0);
        rl = (mfull != 0) ? mwr : 0;
        rw = 0;
    endtask

    task automatic model_cap(logic [63:0] d);
        mem[mwr] = d;
        if (mwr == 63) mfull = 1;
        mwr = (mwr + 1) % 64;
    endtask

    task automatic capture(logic [63:0] d);
        model_cap(d);
        cap_valid = 1'b1; cap_data = d;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic arm();
        armed = 1'b1; mwr = 0; mfull = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic disarm_with_capture(logic [63:0] d);
        model_cap(d);
        armed = 1'b0; cap_valid = 1'b1; cap_data = d;
        @(negedge clk);
        cap_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rdata == 16'h0 && rvalid == 1'b0, "R9 reset outputs", rdata, 16'h0);

        // first session: 11 lines, last one on the disarm cycle (R7)
        arm();
        for (int i = 0; i < 10; i++) begin
            capture(mk(i));
            if (i % 3 == 0) @(negedge clk);
        end
        disarm_with_capture(mk(10));

        bus_read(2'b11, 1'b0, 1'b0, "R4 locked read");
        bus_write(2'b01, 1'b0);
        bus_write(2'b11, 1'b1);
        bus_read(2'b11, 1'b0, 1'b0, "R11 bad write keeps lock");

        unlock_and_seek();
        for (int w = 0; w < 4; w++) bus_read(2'b11, 1'b0, 1'b1, "R1 word order line 0");
        bus_read(2'b10, 1'b0, 1'b0, "R5 byte read zero");
        bus_read(2'b11, 1'b1, 1'b0, "R5 misaligned read zero");
        bus_read(2'b11, 1'b0, 1'b1, "R5 no advance after bad read");
        secured = 1'b1;
        bus_read(2'b11, 1'b0, 1'b0, "R6 secured read zero");
        secured = 1'b0;
        bus_read(2'b11, 1'b0, 1'b1, "R6 no advance after secured");
        bus_write(2'b11, 1'b0);
        for (int w = 0; w < 2; w++) bus_read(2'b11, 1'b0, 1'b1, "R4 unlock write keeps data");
        for (int n = 0; n < 32; n++) bus_read(2'b11, 1'b0, 1'b1, "R2 advance through lines");

        // read in the same cycle as arming (R3)
        armed = 1'b1; mwr = 0; mfull = 0;
        bus_read(2'b11, 1'b0, 1'b0, "R3 read on arm edge");
        bus_read(2'b11, 1'b0, 1'b0, "R3 read while armed");
        bus_write(2'b11, 1'b0);
        for (int i = 0; i < 69; i++) capture(mk(100 + i));
        disarm_with_capture(mk(169));
        bus_read(2'b11, 1'b0, 1'b0, "R4 armed write did not unlock");

        unlock_and_seek();
        for (int n = 0; n < 257; n++) bus_read(2'b11, 1'b0, 1'b1, "R8 R2 oldest first and wrap");

        // reset keeps contents (R9)
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mwr = 0; mfull = 0;
        check(rdata == 16'h0 && rvalid == 1'b0, "R9 outputs after reset", rdata, 16'h0);
        bus_read(2'b11, 1'b0, 1'b0, "R9 locked after reset");
        unlock_and_seek();
        for (int w = 0; w < 4; w++) bus_read(2'b11, 1'b0, 1'b1, "R9 contents survive reset");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0)
            check(1'b0, "R10 missing responses", 16'(exp_q.size()), 16'h0);
        finish_run();
    end
endmodule